// File: doc/BRIEF.md
# I2C Address-Match Wakeup Controller

This block sits on an always-on, low-rate clock beside a sleeping I2C slave. It lets the system stay asleep through bus traffic that concerns other devices and wakes it only when the slave's own address is seen. A START on the bus makes it ask the clock generator for the slave clock. It holds SCL low until that clock is reported running, then lets go and shifts in the first byte.

If the first byte is a high-speed master code, the block switches to HS mode. It lets the not-acknowledged slot pass, waits for the repeated START and shifts in the address byte. A matching address raises a full-system wake request towards the power manager. The block then keeps the slave clock requested until the transfer ends with a STOP. A mismatch drops the clock request at once and the block goes back to waiting for the next START.

The clock generator and the power manager are each reached through a level request and acknowledge pair. Moving data after the wake belongs to the normal slave logic and is not part of this block.

Top module: `i2c_addr_wake`

## Requirements
- R1: When a START (SDA falling while SCL is high) is seen in the sleep state, `clk_req` goes to 1 and `scl_oe` holds SCL low for as long as `clk_ack` stays 0, however long that takes.
- R2: SCL is released within one clock of `clk_ack` being seen high. The next eight SCL rising edges shift in one byte, most significant bit first.
- R3: A first byte whose upper five bits are 00001 (a master code) sets `hs_mode` to 1 and does not wake the system. The block then ignores the following SCL pulse, waits for a repeated START and takes the next eight bits as the address byte.
- R4: An address byte whose bits 7:1 equal `own_addr` raises `wake_req`, whatever the value of bit 0 (R/W). `wake_req` stays at 1 until `wake_ack` is 1, and `clk_req` stays at 1 throughout.
- R5: An address byte whose bits 7:1 differ from `own_addr` never raises `wake_req`. It drops `clk_req` right after the eighth bit and returns the block to the sleep state.
- R6: `hs_mode` stays at 1 through a later address mismatch and is cleared only by a STOP (SDA rising while SCL is high).
- R7: A STOP or a repeated START before an address match abandons the sequence. `clk_req` returns to 0 and no wake is raised for the rest of that transfer.
- R8: After `wake_ack`, `wake_req` returns to 0 while `clk_req` stays at 1 until a STOP, after which `clk_req` is 0.
- R9: While asleep, SCL pulses with no START condition leave `clk_req` and `scl_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-power clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| own_addr | input | 7 | Programmed 7-bit slave address |
| clk_ack | input | 1 | Slave clock reported running |
| wake_ack | input | 1 | Power manager accepted the wake |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| clk_req | output | 1 | Request the slave clock |
| wake_req | output | 1 | Full-system wake request |
| hs_mode | output | 1 | High-speed mode is active |

## Verification
The hardest state to reach from the ports is an HS-mode address mismatch. Getting there takes a master code, an ignored acknowledge slot, a repeated START and then a foreign address. After that the clock request must be gone while `hs_mode` still reads 1 up to the STOP. The bench plays all eight master codes, each followed by a matching read address, a matching write address and a foreign address, and samples `hs_mode` on both sides of the STOP. A full sweep of all 256 first-byte values, with a clock-acknowledge latency that changes on every transfer, covers the match rule, the master-code pattern and stretching of varying length.

// File: rtl/i2c_addr_wake.sv
module i2c_addr_wake #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] MC_PREFIX   = 5'b00001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [6:0] own_addr,
  input  logic       clk_ack,
  input  logic       wake_ack,
  output logic       scl_oe,
  output logic       clk_req,
  output logic       wake_req,
  output logic       hs_mode
);

  localparam logic [2:0] S_IDLE    = 3'd0;
  localparam logic [2:0] S_STRETCH = 3'd1;
  localparam logic [2:0] S_RX1     = 3'd2;
  localparam logic [2:0] S_MCW     = 3'd3;
  localparam logic [2:0] S_RX2     = 3'd4;
  localparam logic [2:0] S_WAKE    = 3'd5;
  localparam logic [2:0] S_AWAKE   = 3'd6;

  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic       scl_d, sda_d;
  logic [2:0] state, state_nxt;
  logic [2:0] bitcnt;
  logic [7:0] shreg;
  logic       hs_q;

  wire scl_s = scl_sr[SYNC_STAGES-1];
  wire sda_s = sda_sr[SYNC_STAGES-1];

  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise  = scl_s & ~scl_d;

  wire [7:0] byte_nxt  = {shreg[6:0], sda_s};
  wire       byte_done = scl_rise && (bitcnt == 3'd7);
  wire       is_mc     = (byte_nxt[7:3] == MC_PREFIX);
  wire       hit       = (byte_nxt[7:1] == own_addr);
  wire       in_rx     = (state == S_RX1) || (state == S_RX2);

  assign scl_oe   = (state == S_STRETCH);
  assign clk_req  = (state != S_IDLE);
  assign wake_req = (state == S_WAKE);
  assign hs_mode  = hs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_comb begin
    state_nxt = state;
    case (state)
      S_IDLE:    if (start_det) state_nxt = S_STRETCH;
      S_STRETCH: if (stop_det) state_nxt = S_IDLE;
                 else if (clk_ack) state_nxt = S_RX1;
      S_RX1:     if (stop_det || start_det) state_nxt = S_IDLE;
                 else if (byte_done) state_nxt = is_mc ? S_MCW : (hit ? S_WAKE : S_IDLE);
      S_MCW:     if (stop_det) state_nxt = S_IDLE;
                 else if (start_det) state_nxt = S_RX2;
      S_RX2:     if (stop_det || start_det) state_nxt = S_IDLE;
                 else if (byte_done) state_nxt = hit ? S_WAKE : S_IDLE;
      S_WAKE:    if (wake_ack) state_nxt = S_AWAKE;
      S_AWAKE:   if (stop_det) state_nxt = S_IDLE;
      default:   state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bitcnt <= 3'd0;
      shreg  <= 8'd0;
      hs_q   <= 1'b0;
    end else begin
      state <= state_nxt;
      if (!in_rx) begin
        bitcnt <= 3'd0;
      end else if (scl_rise) begin
        bitcnt <= bitcnt + 3'd1;
        shreg  <= byte_nxt;
      end
      if (stop_det)
        hs_q <= 1'b0;
      else if (state == S_RX1 && byte_done && is_mc && !start_det)
        hs_q <= 1'b1;
    end
  end

endmodule

// File: rtl/i2c_addr_wake_chk.sv
module i2c_addr_wake_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic clk_req,
  input logic clk_ack,
  input logic wake_req,
  input logic wake_ack,
  input logic hs_mode,
  input logic stop_det
);

  p_stretch_has_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> clk_req);

  p_release_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> $past(clk_ack));

  p_wake_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !wake_ack) |=> wake_req);

  p_wake_with_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (clk_req && !scl_oe));

  p_hs_ends_on_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_mode) |-> $past(stop_det));

  p_stop_drops_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !wake_req) |=> !clk_req);

endmodule

bind i2c_addr_wake i2c_addr_wake_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_oe   (scl_oe),
  .clk_req  (clk_req),
  .clk_ack  (clk_ack),
  .wake_req (wake_req),
  .wake_ack (wake_ack),
  .hs_mode  (hs_mode),
  .stop_det (stop_det)
);

// File: tb/i2c_addr_wake_tb.sv
`timescale 1ns/1ps
module i2c_addr_wake_tb;

  localparam int H = 6;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic clk_ack = 1'b0, wake_ack = 1'b0;
  logic scl_oe, clk_req, wake_req, hs_mode;
  logic scl_ln;
  int   cur_lat = 8;
  int   lat_cnt = 0, wk_cnt = 0;
  int   checks = 0, errors = 0;
  int   cyc = 0;

  always #2 clk = ~clk;

  assign scl_ln = scl_m & ~scl_oe;

  i2c_addr_wake u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_ln), .sda_i(sda_m),
    .own_addr(OWN), .clk_ack(clk_ack), .wake_ack(wake_ack),
    .scl_oe(scl_oe), .clk_req(clk_req), .wake_req(wake_req), .hs_mode(hs_mode)
  );

  always @(negedge clk) begin
    if (!clk_req) begin
      clk_ack <= 1'b0; lat_cnt <= 0;
    end else if (!clk_ack) begin
      if (lat_cnt >= cur_lat) clk_ack <= 1'b1;
      else lat_cnt <= lat_cnt + 1;
    end
    if (!wake_req) begin
      wake_ack <= 1'b0; wk_cnt <= 0;
    end else if (!wake_ack) begin
      if (wk_cnt >= 12) wake_ack <= 1'b1;
      else wk_cnt <= wk_cnt + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    @(negedge clk);
    while (!scl_ln) @(negedge clk);
  endtask

  task automatic start_cond(input bit chk_stretch);
    sda_m = 1'b1; scl_m = 1'b1;
    wait_scl_high();
    wait_cyc(H);
    sda_m = 1'b0;
    wait_cyc(H);
    if (chk_stretch) begin
      check("R1 scl_oe", scl_oe, 1);
      check("R1 clk_req", clk_req, 1);
      check("R1 line", scl_ln, 0);
    end
    scl_m = 1'b0;
    wait_cyc(H);
  endtask

  task automatic rep_start();
    sda_m = 1'b1;
    wait_cyc(H);
    scl_m = 1'b1;
    wait_scl_high();
    wait_cyc(H);
    sda_m = 1'b0;
    wait_cyc(H);
    scl_m = 1'b0;
    wait_cyc(H);
  endtask

  task automatic stop_cond();
    sda_m = 1'b0;
    wait_cyc(H);
    scl_m = 1'b1;
    wait_scl_high();
    wait_cyc(H);
    sda_m = 1'b1;
    wait_cyc(H);
  endtask

  task automatic send_bit(input logic b, input bit chk_ack);
    sda_m = b;
    wait_cyc(H);
    scl_m = 1'b1;
    wait_scl_high();
    if (chk_ack) check("R2 release only with clk_ack", clk_ack, 1);
    wait_cyc(H);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit first);
    for (int i = 7; i >= 0; i--) send_bit(b[i], first && (i == 7));
  endtask

  task automatic finish_hit();
    send_bit(1'b1, 1'b0);
    wait_cyc(20);
    check("R8 wake_req cleared after ack", wake_req, 0);
    check("R8 clk_req kept", clk_req, 1);
    stop_cond();
    check("R8 clk_req after stop", clk_req, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    check("R1 reset clk_req", clk_req, 0);
    check("R1 reset scl_oe", scl_oe, 0);
    check("R4 reset wake_req", wake_req, 0);
    check("R6 reset hs_mode", hs_mode, 0);

    // R9: SCL pulses without START
    for (int i = 0; i < 16; i++) begin
      scl_m = 1'b0; wait_cyc(H);
      sda_m = i[0]; wait_cyc(H);
      scl_m = 1'b1; wait_cyc(H);
      check("R9 clk_req", clk_req, 0);
      check("R9 scl_oe", scl_oe, 0);
    end
    sda_m = 1'b1; wait_cyc(H);

    // R4 R5 R3: sweep every first byte
    for (int b = 0; b < 256; b++) begin
      logic [7:0] by;
      bit mc, hit;
      by = b[7:0];
      mc = (by[7:3] == 5'b00001);
      hit = !mc && (by[7:1] == OWN);
      cur_lat = 8 + (b % 16);
      start_cond(1'b1);
      send_byte(by, 1'b1);
      check(mc ? "R3 no wake on master code" : (hit ? "R4 wake on match" : "R5 no wake on miss"),
            wake_req, hit);
      check(hit || mc ? "R4 clock kept" : "R5 clock dropped", clk_req, hit || mc);
      check("R3 hs_mode after first byte", hs_mode, mc);
      if (hit) finish_hit();
      else begin
        send_bit(1'b1, 1'b0);
        stop_cond();
        check("R6 hs cleared by stop", hs_mode, 0);
        check("R5 idle after stop", clk_req, 0);
      end
    end

    // R3 R6: HS entry, repeated START, address
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] ab;
        ab = (k == 2) ? {OWN ^ 7'h11, 1'b0} : {OWN, k[0]};
        cur_lat = 9 + m + k;
        start_cond(1'b1);
        send_byte({5'b00001, m[2:0]}, 1'b1);
        check("R3 hs set by master code", hs_mode, 1);
        check("R3 no wake on master code", wake_req, 0);
        send_bit(1'b1, 1'b0);
        check("R3 waiting keeps clock", clk_req, 1);
        rep_start();
        send_byte(ab, 1'b0);
        check(k == 2 ? "R5 HS miss no wake" : "R4 HS match wake", wake_req, k != 2);
        if (k != 2) begin
          finish_hit();
        end else begin
          check("R5 HS miss drops clock", clk_req, 0);
          send_bit(1'b1, 1'b0);
          wait_cyc(H);
          check("R6 hs kept until stop", hs_mode, 1);
          stop_cond();
        end
        check("R6 hs cleared after stop", hs_mode, 0);
      end
    end

    // R7: STOP in the middle of a matching address
    cur_lat = 10;
    start_cond(1'b1);
    send_bit(OWN[6], 1'b1);
    send_bit(OWN[5], 1'b0);
    send_bit(OWN[4], 1'b0);
    stop_cond();
    check("R7 stop aborts clk_req", clk_req, 0);
    check("R7 stop aborts wake", wake_req, 0);

    // R7: repeated START in the middle of a matching address
    start_cond(1'b1);
    send_bit(OWN[6], 1'b1);
    send_bit(OWN[5], 1'b0);
    send_bit(OWN[4], 1'b0);
    rep_start();
    check("R7 rep start aborts clk_req", clk_req, 0);
    for (int i = 3; i >= 0; i--) send_bit(OWN[i], 1'b0);
    send_bit(1'b0, 1'b0);
    check("R7 no wake after abort", wake_req, 0);
    check("R7 clock stays off", clk_req, 0);
    stop_cond();

    // R7: STOP after master code while waiting for repeated START
    start_cond(1'b1);
    send_byte(8'h0B, 1'b1);
    send_bit(1'b1, 1'b0);
    stop_cond();
    check("R7 stop in HS wait drops clock", clk_req, 0);
    check("R6 stop in HS wait clears hs", hs_mode, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule